// File: doc/BRIEF.md
# Data-Space Access Router

This block sits between a small processor core's load/store and port-I/O paths and everything that can answer a byte access. One request interface carries either a data-space address or an I/O port number. The router decides where the byte goes: to the core register file, to a handful of registers it keeps itself, or out to an external memory/peripheral bus.

The data space is laid out as registers first, then an I/O window, then memory. With the defaults the register file covers addresses 0x00–0x1F, the 64-port I/O window covers 0x20–0x5F, and memory begins at 0x60. The top eight ports of the I/O window are held inside the router. Four of them are extended-address page bytes, one is an indirect-jump extension byte, two are the stack pointer bytes, and one is a window onto the status register. Every other port is sent to the external bus. Feature parameters decide which page bytes and whether the stack-pointer high byte exist. A write to a register that is absent leaves it unchanged.

Internal reads answer in the cycle of the request. External reads answer one cycle after the bus request, when the bus raises its valid strobe.

Top module: `dsr_router`

## Requirements
- R1: A data access with address below RF_SIZE (32) goes to the register file. A write raises `rfWe` with `rfAddr` equal to the address and `rfWdata` equal to the data. A read returns `rfRdata` in the same cycle. The external bus stays idle for both.
- R2: A data address A in the I/O window (RF_SIZE ≤ A < RF_SIZE+IO_SIZE) selects port A−RF_SIZE. Ports 0x00–0x37 are forwarded to the external bus at address IO_BASE+port (0x20+port by default), carrying the 8-bit write data.
- R3: A data address at or above RF_SIZE+IO_SIZE (0x60) is forwarded to the external bus unchanged. An external read raises `rspValid` with the bus data one cycle after `extReq`, and raises nothing in the request cycle.
- R4: Ports 0x38, 0x39, 0x3A and 0x3B are the D, X, Y and Z page bytes. A write puts the byte in bits 23:16 of the 24-bit output, with bits 15:0 at zero. A read returns the stored byte.
- R5: A write to a page byte whose bit in PAGE_EN is clear (bit 0 = D … bit 3 = Z) is ignored. That byte reads as zero and its output stays zero.
- R6: Port 0x3C is the indirect-jump extension byte. It is always writable and is placed in bits 23:16 of `jmpExt`.
- R7: Port 0x3D reads and writes `stackPtr[7:0]`. Port 0x3E reads and writes `stackPtr[15:8]` only when WIDE_SP=1. When WIDE_SP=0, a write to 0x3E is ignored and a read returns 0.
- R8: Port 0x3F is the status register. A write raises `sregWe` with `sregWdata` equal to the data for one cycle. A read returns `sregRdata` in the same cycle.
- R9: With `reqIsPort`=1 the low 6 bits of `reqAddr` are a port number and the upper bits are ignored. The access behaves exactly like a data access to address RF_SIZE+port.
- R10: An access to the register file or to an internal port never raises `extReq`. An internal read raises `rspValid` in the request cycle, and a write never raises `rspValid`.
- R11: After reset all page bytes and the jump byte are zero. `stackPtr` equals SP_RESET, with the high byte forced to zero when WIDE_SP=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsPort | input | 1 | 1 = reqAddr carries a port number |
| reqAddr | input | ADDR_W | Data address or port number |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | Read data valid |
| rspData | output | 8 | Read data |
| rfWe | output | 1 | Register-file write strobe |
| rfAddr | output | RF_W | Register-file index |
| rfWdata | output | 8 | Register-file write byte |
| rfRdata | input | 8 | Register-file read byte for rfAddr |
| sregWe | output | 1 | Status register write strobe |
| sregWdata | output | 8 | Packed status byte to unpack |
| sregRdata | input | 8 | Packed status byte |
| extReq | output | 1 | External bus request |
| extWe | output | 1 | External bus write |
| extAddr | output | ADDR_W | External bus address |
| extWdata | output | 8 | External bus write byte |
| extRdata | input | 8 | External bus read byte |
| extRvalid | input | 1 | External read data valid |
| pageD | output | 24 | D page value |
| pageX | output | 24 | X page value |
| pageY | output | 24 | Y page value |
| pageZ | output | 24 | Z page value |
| jmpExt | output | 24 | Indirect-jump extension value |
| stackPtr | output | 16 | Stack pointer |

## Verification
A wrong decode boundary is visible in the request cycle itself. The byte lands on `rfWe` or `extReq` at the wrong address, or an internal port leaks onto the bus. A corrupted page, jump or stack byte shows on its output one cycle after the write, and on `rspData` at the next read of that port. A lost external-read pending state shows as a missing or early `rspValid` one cycle after the bus request. Every address of the small data space and every port is therefore swept, and the special ports are read back through both addressing forms.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  // Index of an internal port counted from the first internal port.
  // The order follows the port numbers and is decoded by the datapath.
  localparam int unsigned SPEC_COUNT = 8;
  localparam logic [2:0] SPEC_JMP    = 3'd4;
  localparam logic [2:0] SPEC_SPLO   = 3'd5;
  localparam logic [2:0] SPEC_SPHI   = 3'd6;
  localparam logic [2:0] SPEC_SREG   = 3'd7;

  typedef struct packed {
    logic       rfSel;    // request addresses the register file
    logic       specWr;   // write to an internal port this cycle
    logic [2:0] specIdx;  // which internal port
    logic       extRsp;   // external read data returning this cycle
  } dsr_strobe_t;
endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int RF_SIZE = 32,
  parameter int IO_SIZE = 64,
  parameter int IO_BASE = 32,
  localparam int RF_W   = $clog2(RF_SIZE),
  localparam int PORT_W = $clog2(IO_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIsPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              extRvalid,
  output dsr_strobe_t       stb,
  output logic              rfWe,
  output logic [RF_W-1:0]   rfAddr,
  output logic              extReq,
  output logic              extWe,
  output logic [ADDR_W-1:0] extAddr,
  output logic              rspValid
);
  localparam logic [ADDR_W-1:0] RF_LIM = ADDR_W'(RF_SIZE);
  localparam logic [ADDR_W-1:0] IO_LIM = ADDR_W'(RF_SIZE + IO_SIZE);
  localparam logic [PORT_W-1:0] SPEC_FIRST = PORT_W'(IO_SIZE - SPEC_COUNT);

  logic              inRf;
  logic              inIo;
  logic              isSpec;
  logic              isExt;
  logic [ADDR_W-1:0] ioOff;
  logic [PORT_W-1:0] portNum;
  logic              pendRd;

  always_comb begin
    ioOff = reqAddr - RF_LIM;
    if (reqIsPort) begin
      inRf    = 1'b0;
      inIo    = 1'b1;
      portNum = reqAddr[PORT_W-1:0];
    end else begin
      inRf    = reqAddr < RF_LIM;
      inIo    = !inRf && (reqAddr < IO_LIM);
      portNum = ioOff[PORT_W-1:0];
    end
    isSpec  = inIo && (portNum >= SPEC_FIRST);
    isExt   = !inRf && !isSpec;
    extAddr = inIo ? (ADDR_W'(IO_BASE) + ADDR_W'(portNum)) : reqAddr;
  end

  assign rfAddr = reqAddr[RF_W-1:0];
  assign rfWe   = reqValid && reqWrite && inRf;
  assign extReq = reqValid && isExt;
  assign extWe  = reqWrite;

  // One outstanding external read; the bus answers in the next cycle.
  always_ff @(posedge clk) begin
    if (!rstN) pendRd <= 1'b0;
    else       pendRd <= reqValid && !reqWrite && isExt;
  end

  assign stb.rfSel   = inRf;
  assign stb.specWr  = reqValid && reqWrite && isSpec;
  assign stb.specIdx = 3'(portNum - SPEC_FIRST);
  assign stb.extRsp  = pendRd && extRvalid;

  assign rspValid = (reqValid && !reqWrite && !isExt) || (pendRd && extRvalid);
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter logic [3:0]  PAGE_EN  = 4'b1111,
  parameter bit          WIDE_SP  = 1'b1,
  parameter logic [15:0] SP_RESET = 16'h0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  dsr_strobe_t     stb,
  input  logic [7:0]      reqWdata,
  input  logic [7:0]      rfRdata,
  input  logic [7:0]      sregRdata,
  input  logic [7:0]      extRdata,
  output logic [7:0]      rspData,
  output logic            sregWe,
  output logic [7:0]      sregWdata,
  output logic [3:0][7:0] pageByte,
  output logic [7:0]      jmpByte,
  output logic [15:0]     stackPtr
);
  logic [7:0] spLo;
  logic [7:0] spHi;
  logic [7:0] specRd;

  for (genvar g = 0; g < 4; g++) begin : gPage
    if (PAGE_EN[g]) begin : gOn
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (stb.specWr && stb.specIdx == 3'(g)) q <= reqWdata;
      end
      assign pageByte[g] = q;
    end else begin : gOff
      assign pageByte[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jmpByte <= '0;
      spLo    <= SP_RESET[7:0];
    end else if (stb.specWr) begin
      if (stb.specIdx == SPEC_JMP)  jmpByte <= reqWdata;
      if (stb.specIdx == SPEC_SPLO) spLo    <= reqWdata;
    end
  end

  if (WIDE_SP) begin : gSpWide
    always_ff @(posedge clk) begin
      if (!rstN) spHi <= SP_RESET[15:8];
      else if (stb.specWr && stb.specIdx == SPEC_SPHI) spHi <= reqWdata;
    end
  end else begin : gSpNarrow
    assign spHi = '0;
  end

  assign stackPtr  = {spHi, spLo};
  assign sregWe    = stb.specWr && (stb.specIdx == SPEC_SREG);
  assign sregWdata = reqWdata;

  always_comb begin
    case (stb.specIdx)
      3'd0, 3'd1, 3'd2, 3'd3: specRd = pageByte[stb.specIdx[1:0]];
      SPEC_JMP:               specRd = jmpByte;
      SPEC_SPLO:              specRd = spLo;
      SPEC_SPHI:              specRd = spHi;
      default:                specRd = sregRdata;
    endcase
  end

  always_comb begin
    if (stb.extRsp)     rspData = extRdata;
    else if (stb.rfSel) rspData = rfRdata;
    else                rspData = specRd;
  end
endmodule

// File: rtl/dsr_router.sv
module dsr_router
  import dsr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          RF_SIZE  = 32,
  parameter int          IO_SIZE  = 64,
  parameter int          IO_BASE  = 32,
  parameter logic [3:0]  PAGE_EN  = 4'b1111,
  parameter bit          WIDE_SP  = 1'b1,
  parameter logic [15:0] SP_RESET = 16'h0000,
  localparam int         RF_W     = $clog2(RF_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIsPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              rfWe,
  output logic [RF_W-1:0]   rfAddr,
  output logic [7:0]        rfWdata,
  input  logic [7:0]        rfRdata,
  output logic              sregWe,
  output logic [7:0]        sregWdata,
  input  logic [7:0]        sregRdata,
  output logic              extReq,
  output logic              extWe,
  output logic [ADDR_W-1:0] extAddr,
  output logic [7:0]        extWdata,
  input  logic [7:0]        extRdata,
  input  logic              extRvalid,
  output logic [23:0]       pageD,
  output logic [23:0]       pageX,
  output logic [23:0]       pageY,
  output logic [23:0]       pageZ,
  output logic [23:0]       jmpExt,
  output logic [15:0]       stackPtr
);
  dsr_strobe_t     stb;
  logic [3:0][7:0] pageByte;
  logic [7:0]      jmpByte;

  dsr_ctrl #(
    .ADDR_W(ADDR_W), .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE), .IO_BASE(IO_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsPort(reqIsPort), .reqAddr(reqAddr), .extRvalid(extRvalid),
    .stb(stb), .rfWe(rfWe), .rfAddr(rfAddr), .extReq(extReq), .extWe(extWe),
    .extAddr(extAddr), .rspValid(rspValid)
  );

  dsr_datapath #(
    .PAGE_EN(PAGE_EN), .WIDE_SP(WIDE_SP), .SP_RESET(SP_RESET)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata), .rfRdata(rfRdata),
    .sregRdata(sregRdata), .extRdata(extRdata), .rspData(rspData),
    .sregWe(sregWe), .sregWdata(sregWdata), .pageByte(pageByte),
    .jmpByte(jmpByte), .stackPtr(stackPtr)
  );

  assign rfWdata  = reqWdata;
  assign extWdata = reqWdata;
  assign pageD    = {pageByte[0], 16'h0000};
  assign pageX    = {pageByte[1], 16'h0000};
  assign pageY    = {pageByte[2], 16'h0000};
  assign pageZ    = {pageByte[3], 16'h0000};
  assign jmpExt   = {jmpByte, 16'h0000};
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        rfWe,
  input logic        sregWe,
  input logic        extReq,
  input logic        extWe,
  input logic        rspValid,
  input logic [23:0] pageD
);
  AST_RF_NO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (!extReq && !sregWe)); // R1

  AST_EXT_RSP_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(reqValid && !reqWrite)) |-> $past(extReq && !extWe)); // R3

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(pageD)); // R4

  AST_SREG_WR: assert property (@(posedge clk) disable iff (!rstN)
    sregWe |-> (reqValid && reqWrite && !extReq)); // R8

  AST_INT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !extReq) |-> rspValid); // R10
endmodule

bind dsr_router dsr_checker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .rfWe(rfWe), .sregWe(sregWe), .extReq(extReq), .extWe(extWe),
  .rspValid(rspValid), .pageD(pageD)
);

// File: tb/tb_dsr_router.sv
module tb_dsr_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] LITE_PAGES = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqIsPort = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rfRdata, sregRdata, extRdata;
  logic        extRvalid;
  logic [7:0]  sregModel;

  logic rspValid, rfWe, sregWe, extReq, extWe;
  logic [7:0] rspData, rfWdata, sregWdata, extWdata;
  logic [4:0] rfAddr;
  logic [15:0] extAddr, stackPtr;
  logic [23:0] pageD, pageX, pageY, pageZ, jmpExt;

  logic lRspValid, lRfWe, lSregWe, lExtReq, lExtWe;
  logic [7:0] lRspData, lRfWdata, lSregWdata, lExtWdata;
  logic [4:0] lRfAddr;
  logic [15:0] lExtAddr, lStackPtr;
  logic [23:0] lPageD, lPageX, lPageY, lPageZ, lJmpExt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsr_router #(.SP_RESET(16'h08FF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsPort(reqIsPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rfWe(rfWe), .rfAddr(rfAddr),
    .rfWdata(rfWdata), .rfRdata(rfRdata), .sregWe(sregWe), .sregWdata(sregWdata),
    .sregRdata(sregRdata), .extReq(extReq), .extWe(extWe), .extAddr(extAddr),
    .extWdata(extWdata), .extRdata(extRdata), .extRvalid(extRvalid),
    .pageD(pageD), .pageX(pageX), .pageY(pageY), .pageZ(pageZ),
    .jmpExt(jmpExt), .stackPtr(stackPtr)
  );

  dsr_router #(.PAGE_EN(LITE_PAGES), .WIDE_SP(1'b0), .SP_RESET(16'h12AB)) dutLite (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsPort(reqIsPort), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(lRspValid), .rspData(lRspData), .rfWe(lRfWe), .rfAddr(lRfAddr),
    .rfWdata(lRfWdata), .rfRdata(rfRdata), .sregWe(lSregWe), .sregWdata(lSregWdata),
    .sregRdata(sregRdata), .extReq(lExtReq), .extWe(lExtWe), .extAddr(lExtAddr),
    .extWdata(lExtWdata), .extRdata(extRdata), .extRvalid(extRvalid),
    .pageD(lPageD), .pageX(lPageX), .pageY(lPageY), .pageZ(lPageZ),
    .jmpExt(lJmpExt), .stackPtr(lStackPtr)
  );

  // Bench models of the register file, status packer and external bus.
  assign rfRdata   = {3'b000, rfAddr} ^ 8'h3C;
  assign sregRdata = sregModel;
  always @(posedge clk) begin
    if (!rstN) sregModel <= 8'h00;
    else if (sregWe) sregModel <= sregWdata;
    extRvalid <= rstN && extReq && !extWe;
    extRdata  <= extAddr[7:0] ^ extAddr[15:8] ^ 8'hA5;
  end

  function automatic logic [7:0] extFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit p, input bit w, input logic [15:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqWrite = w; reqIsPort = p; reqAddr = a; reqWdata = d;
    #2;
  endtask

  task automatic release_req();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqIsPort = 1'b0;
  endtask

  // External read: request cycle checked, then the response one cycle later.
  task automatic extRead(input string req, input bit p, input logic [15:0] a,
                         input logic [15:0] expAddr);
    drive(p, 1'b0, a, 8'h00);
    chkEq(req, {29'd0, extReq, extWe, rspValid}, {29'd0, 3'b100});
    chkEq(req, {16'd0, extAddr}, {16'd0, expAddr});
    release_req();
    #2;
    chkEq(req, {23'd0, rspValid, rspData}, {23'd0, 1'b1, extFn(expAddr)});
    @(negedge clk);
  endtask

  task automatic intRead(input string req, input bit p, input logic [15:0] a,
                         input logic [7:0] exp, input logic [7:0] expLite);
    drive(p, 1'b0, a, 8'h00);
    chkEq(req, {22'd0, extReq, rspValid, rspData}, {22'd0, 1'b0, 1'b1, exp});
    chkEq(req, {22'd0, lExtReq, lRspValid, lRspData}, {22'd0, 1'b0, 1'b1, expLite});
    release_req();
  endtask

  task automatic specWrite(input string req, input bit p, input logic [15:0] a,
                           input logic [7:0] d);
    drive(p, 1'b1, a, d);
    chkEq(req, {28'd0, extReq, rfWe, rspValid, lExtReq}, 32'd0); // R10
    release_req();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R11: reset state
    chkEq("R11", pageD | pageX | pageY | pageZ | jmpExt, 32'd0);
    chkEq("R11", {16'd0, stackPtr}, 32'h08FF);
    chkEq("R11", {16'd0, lStackPtr}, 32'h00AB);
    @(negedge clk);

    // Write sweep over the whole small data space except the internal ports.
    for (int a = 0; a < 128; a++) begin
      logic [7:0] d;
      if (a >= 'h58 && a < 'h60) continue;
      d = 8'(a) ^ 8'h5F;
      drive(1'b0, 1'b1, 16'(a), d);
      if (a < 32) begin
        chkEq("R1", {16'd0, rfWe, extReq, rspValid, rfAddr, rfWdata},
              {16'd0, 3'b100, 5'(a), d});
      end else begin
        chkEq(a < 96 ? "R2" : "R3", {16'd0, rfWe, extReq, extWe, rspValid, 4'd0, extWdata},
              {16'd0, 4'b0110, 4'd0, d});
        chkEq(a < 96 ? "R2" : "R3", {16'd0, extAddr}, 32'(a));
      end
      release_req();
    end

    // Read sweep.
    for (int a = 0; a < 128; a++) begin
      if (a >= 'h58 && a < 'h60) continue;
      if (a < 32) begin
        drive(1'b0, 1'b0, 16'(a), 8'h00);
        chkEq("R1", {22'd0, extReq, rspValid, rspData}, {22'd0, 2'b01, 8'(a) ^ 8'h3C});
        release_req();
      end else begin
        extRead(a < 96 ? "R2" : "R3", 1'b0, 16'(a), 16'(a));
      end
    end

    // Far memory addresses.
    extRead("R3", 1'b0, 16'h1234, 16'h1234);
    extRead("R3", 1'b0, 16'hFFFF, 16'hFFFF);
    drive(1'b0, 1'b1, 16'hBEEF, 8'h77);
    chkEq("R3", {15'd0, extReq, extAddr}, {15'd0, 1'b1, 16'hBEEF});
    release_req();

    // Port-number addressing of the forwarded ports, upper bits set to junk.
    for (int p = 0; p < 56; p++) begin
      drive(1'b1, 1'b1, {10'h2A5, 6'(p)}, 8'(p) ^ 8'hC6);
      chkEq("R9", {8'd0, extReq, extWe, rfWe, 5'd0, extAddr}, {8'd0, 3'b110, 5'd0, 16'(32 + p)});
      chkEq("R9", {24'd0, extWdata}, {24'd0, 8'(p) ^ 8'hC6});
      release_req();
      extRead("R9", 1'b1, {10'h2A5, 6'(p)}, 16'(32 + p));
    end

    // Page bytes written by port number, read back by data address.
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = 8'h11 * 8'(i + 1);
      specWrite("R4", 1'b1, 16'('h38 + i), v);
    end
    chkEq("R4", pageD, {8'h11, 16'h0});
    chkEq("R4", pageX, {8'h22, 16'h0});
    chkEq("R4", pageY, {8'h33, 16'h0});
    chkEq("R4", pageZ, {8'h44, 16'h0});
    chkEq("R5", lPageD, {8'h11, 16'h0});
    chkEq("R5", lPageX, 32'd0);
    chkEq("R5", lPageY, {8'h33, 16'h0});
    chkEq("R5", lPageZ, 32'd0);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = 8'h11 * 8'(i + 1);
      intRead("R4 R5", 1'b0, 16'('h58 + i), v, LITE_PAGES[i] ? v : 8'h00);
    end

    // Jump extension byte: written by data address, read by port.
    specWrite("R6", 1'b0, 16'h005C, 8'hC3);
    chkEq("R6", jmpExt, {8'hC3, 16'h0});
    chkEq("R6", lJmpExt, {8'hC3, 16'h0});
    intRead("R6", 1'b1, 16'h003C, 8'hC3, 8'hC3);

    // Stack pointer bytes.
    specWrite("R7", 1'b1, 16'h003D, 8'h34);
    specWrite("R7", 1'b0, 16'h005E, 8'h9A);
    chkEq("R7", {16'd0, stackPtr}, 32'h9A34);
    chkEq("R7", {16'd0, lStackPtr}, 32'h0034);
    intRead("R7", 1'b1, 16'h003E, 8'h9A, 8'h00);
    intRead("R7", 1'b0, 16'h005D, 8'h34, 8'h34);

    // Status register window.
    drive(1'b1, 1'b1, 16'h003F, 8'h81);
    chkEq("R8", {14'd0, sregWe, lSregWe, extReq, rfWe, sregWdata, lSregWdata},
          {14'd0, 4'b1100, 8'h81, 8'h81});
    release_req();
    #2;
    chkEq("R8", {31'd0, sregWe}, 32'd0);
    intRead("R8", 1'b0, 16'h005F, 8'h81, 8'h81);
    specWrite("R8", 1'b0, 16'h005F, 8'h5E);
    intRead("R8", 1'b1, 16'h003F, 8'h5E, 8'h5E);

    // Other internal values untouched by the status and stack accesses.
    chkEq("R4", pageZ, {8'h44, 16'h0});
    chkEq("R6", jmpExt, {8'hC3, 16'h0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule